// File: doc/BRIEF.md
# Audio De-emphasis Shelving Filter

This block removes high-frequency pre-emphasis from a stream of signed 24-bit PCM samples. Some recordings boost their treble before storage to reduce noise; this filter applies the inverse curve. It is a first-order pole/zero shelf. The pole has a 50 µs time constant, with a corner near 3.18 kHz. The zero has a 15 µs time constant, with a corner near 10.6 kHz. Gain is 0 dB at low frequency and falls to roughly -10 dB toward the top of the band. The coefficients are fixed at elaboration for a 48 kHz sample rate.

Each sample arrives with a one-cycle valid strobe. Two further inputs gate the filter: an enable bit and a two-bit speed-mode code. Filtering takes place only when the enable bit is set and the speed mode is single-speed. In every other case the sample passes through unchanged. Both paths have the same two-cycle latency, so switching between them never reorders or drops samples. Whenever a sample takes the bypass path, the filter's history is wiped. The first filtered sample after a bypass therefore starts from a clean state and produces no click from stale history.

Top module: `deemph_shelf`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_sample` is 0.
- R2: Every input sample yields exactly one output. If `in_valid` is high in clock cycle n, then `out_valid` is high in cycle n+2. `out_valid` is never high without such an input.
- R3: A sample taken while `deemph_en` is 0 appears on `out_sample` bit-exactly, over the full 24-bit two's complement range.
- R4: `speed_mode` encodes the rate as follows: 2'b00 is single-speed, 2'b01 is double-speed, 2'b10 is quad-speed and 2'b11 is reserved. Any code other than 2'b00 forces the bit-exact bypass of R3, even when `deemph_en` is 1.
- R5: When filtering is active, a constant input settles to within ±4 LSB of the input value (0 dB at DC).
- R6: When filtering is active, an alternating +A/−A input settles to an output amplitude of 0.300·A ±1%, which is about −10.5 dB.
- R7: When filtering is active, the output follows y[n] = b0·x[n] + b1·x[n−1] − a1·y[n−1]. The coefficients are in Q2.22 (value / 2^22): b0 = 1764500, b1 = −318189, a1 = −2747992. The result is rounded to the nearest integer and clamped to the 24-bit signed range. From a cleared state, an impulse matches this recursion within ±2 LSB.
- R8: A sample that takes the bypass path clears both x[n−1] and y[n−1]. The next filtered output for input x is therefore b0·x within ±2 LSB, whatever the earlier history was.
- R9: `out_sample` holds its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| deemph_en | input | 1 | Enables de-emphasis |
| speed_mode | input | 2 | Rate code; 2'b00 is single-speed |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Signed output sample |

## Verification
The assertions check three rules on every cycle: the two-cycle valid timing, the bit-exact bypass under either gating condition, and the holding of the output between strobes. None of these depends on stimulus history. The frequency response cannot be judged from any single cycle. This covers the DC gain, the near-Nyquist attenuation, the exact impulse recursion and the history wipe after a bypass sample. Only the bench's scenarios can show these, by settling long sample streams and comparing them against values computed in real arithmetic.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_RSVD   = 2'b11
   } speed_e;

   // Q2.22 coefficients for 48 kHz, bilinear mapping of (1+s*15us)/(1+s*50us)
   localparam int DEF_COEF_W    = 24;
   localparam int DEF_COEF_FRAC = 22;
   localparam int DEF_B0        = 1764500;
   localparam int DEF_B1        = -318189;
   localparam int DEF_A1        = -2747992;

endpackage

// File: rtl/deemph_ff.sv
// Stage 1: feed-forward products and input history.
module deemph_ff #(
   parameter int DATA_W = 24,
   parameter int ACC_W  = 56,
   parameter int B0     = 0,
   parameter int B1     = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic                     act,
   output logic                     s1_valid,
   output logic                     s1_act,
   output logic signed [ACC_W-1:0]  s1_acc,
   output logic signed [DATA_W-1:0] s1_raw
);

   logic signed [DATA_W-1:0] x_prev;
   logic signed [ACC_W-1:0]  xe, xpe, c0, c1, p0, p1;

   always_comb begin
      xe  = ACC_W'(in_sample);
      xpe = ACC_W'(x_prev);
      c0  = ACC_W'(B0);
      c1  = ACC_W'(B1);
      p0  = xe * c0;
      p1  = xpe * c1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_act   <= 1'b0;
         s1_acc   <= '0;
         s1_raw   <= '0;
         x_prev   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_act <= act;
            s1_raw <= in_sample;
            s1_acc <= p0 + p1;
            x_prev <= act ? in_sample : '0;
         end
      end
   end

endmodule

// File: rtl/deemph_fb.sv
// Stage 2: recursive term, rounding, clamping and bypass selection.
module deemph_fb #(
   parameter int DATA_W        = 24,
   parameter int ACC_W         = 56,
   parameter int FRAC          = 22,
   parameter int A1            = 0,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     s1_valid,
   input  logic                     s1_act,
   input  logic signed [ACC_W-1:0]  s1_acc,
   input  logic signed [DATA_W-1:0] s1_raw,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_sample
);

   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

   logic signed [DATA_W-1:0] y_prev;
   logic signed [ACC_W-1:0]  ye, ca, fb, sum, rnd, shifted;
   logic signed [DATA_W-1:0] ysat;

   always_comb begin
      ye  = ACC_W'(y_prev);
      ca  = ACC_W'(A1);
      fb  = ye * ca;
      sum = s1_acc - fb;
   end

   generate
      if (ROUND_NEAREST) begin : g_round
         localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC-1));
         assign rnd = sum + HALF;
      end else begin : g_trunc
         assign rnd = sum;
      end
   endgenerate

   always_comb begin
      shifted = rnd >>> FRAC;
      if (shifted > MAXV)      ysat = MAXV[DATA_W-1:0];
      else if (shifted < MINV) ysat = MINV[DATA_W-1:0];
      else                     ysat = shifted[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
         y_prev     <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            if (s1_act) begin
               out_sample <= ysat;
               y_prev     <= ysat;
            end else begin
               out_sample <= s1_raw;
               y_prev     <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/deemph_shelf.sv
module deemph_shelf
   import deemph_pkg::*;
#(
   parameter int DATA_W        = 24,
   parameter int COEF_W        = DEF_COEF_W,
   parameter int COEF_FRAC     = DEF_COEF_FRAC,
   parameter int ACC_W         = 56,
   parameter int B0            = DEF_B0,
   parameter int B1            = DEF_B1,
   parameter int A1            = DEF_A1,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_sample,
   input  logic              deemph_en,
   input  logic [1:0]        speed_mode,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_sample
);

   localparam int MIN_ACC_W = DATA_W + COEF_W + 2;

   generate
      if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data
         $error("deemph_shelf: DATA_W out of range");
      end
      if (COEF_FRAC >= COEF_W || COEF_FRAC < 2) begin : g_bad_frac
         $error("deemph_shelf: COEF_FRAC must lie below COEF_W");
      end
      if (ACC_W < MIN_ACC_W || ACC_W > 64) begin : g_bad_acc
         $error("deemph_shelf: ACC_W too narrow for products");
      end
   endgenerate

   logic                     act;
   logic                     s1_valid, s1_act;
   logic signed [ACC_W-1:0]  s1_acc;
   logic signed [DATA_W-1:0] s1_raw;
   logic signed [DATA_W-1:0] y_out;

   assign act = deemph_en && (speed_e'(speed_mode) == SPD_SINGLE);

   deemph_ff #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .B0     (B0),
      .B1     (B1)
   ) u_ff (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sample ($signed(in_sample)),
      .act       (act),
      .s1_valid  (s1_valid),
      .s1_act    (s1_act),
      .s1_acc    (s1_acc),
      .s1_raw    (s1_raw)
   );

   deemph_fb #(
      .DATA_W        (DATA_W),
      .ACC_W         (ACC_W),
      .FRAC          (COEF_FRAC),
      .A1            (A1),
      .ROUND_NEAREST (ROUND_NEAREST)
   ) u_fb (
      .clk        (clk),
      .rst_n      (rst_n),
      .s1_valid   (s1_valid),
      .s1_act     (s1_act),
      .s1_acc     (s1_acc),
      .s1_raw     (s1_raw),
      .out_valid  (out_valid),
      .out_sample (y_out)
   );

   assign out_sample = y_out;

endmodule

// File: rtl/deemph_shelf_chk.sv
module deemph_shelf_chk #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_sample,
   input logic              deemph_en,
   input logic [1:0]        speed_mode,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_sample
);

   logic              v1, v2, a1, a2;
   logic [DATA_W-1:0] x1, x2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0;
         a1 <= 1'b0; a2 <= 1'b0;
         x1 <= '0;   x2 <= '0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         a1 <= deemph_en && (speed_mode == 2'b00);
         a2 <= a1;
         x1 <= in_sample;
         x2 <= x1;
      end
   end

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_sample == '0));

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v2);

   // covers R3 (enable low) and R4 (speed code not single)
   assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !a2) |-> (out_sample == x2));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_sample));

endmodule

bind deemph_shelf deemph_shelf_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sample  (in_sample),
   .deemph_en  (deemph_en),
   .speed_mode (speed_mode),
   .out_valid  (out_valid),
   .out_sample (out_sample)
);

// File: tb/deemph_shelf_tb.sv
module deemph_shelf_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [23:0] in_sample;
   logic        deemph_en;
   logic [1:0]  speed_mode;
   logic        out_valid;
   logic [23:0] out_sample;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   real rb0 = 1764500.0 / 4194304.0;
   real rb1 = -318189.0 / 4194304.0;
   real ra1 = -2747992.0 / 4194304.0;

   always #(CLK_PERIOD/2) clk = ~clk;

   deemph_shelf u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .deemph_en(deemph_en), .speed_mode(speed_mode),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic real rabs(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   // drive one sample, verify the two-cycle strobe timing, return output
   task automatic push(input int x, output int y);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = 24'(x);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R2 early strobe", int'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1'b1, "R2 strobe at n+2", int'(out_valid), 1);
      y = int'($signed(out_sample));
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 single strobe", int'(out_valid), 0);
      chk(int'($signed(out_sample)) == y, "R9 hold", int'($signed(out_sample)), y);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int y, yp, yn;
      real e0, e1, e2, amp;
      rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
      deemph_en = 1'b0; speed_mode = 2'b00;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      chk(out_sample == 24'd0, "R1 sample in reset", int'(out_sample), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: bypass sweep with enable low, including extremes
      deemph_en = 1'b0;
      for (int i = 0; i < 48; i++) begin
         int v;
         v = (i == 0) ? -8388608 : (i == 1) ? 8388607 : (i * 349525) - 8388608;
         push(v, y);
         chk(y == v, "R3 bypass exact", y, v);
      end

      // R4: non-single speed codes bypass even when enabled
      deemph_en = 1'b1;
      for (int m = 1; m < 4; m++) begin
         speed_mode = 2'(m);
         for (int i = 0; i < 6; i++) begin
            int v;
            v = (i % 2 == 0) ? 3000000 + i : -2500000 - i;
            push(v, y);
            chk(y == v, "R4 speed-mode bypass", y, v);
         end
      end

      // R7/R8: impulse from cleared state (previous sample was bypass)
      speed_mode = 2'b00;
      push(1000000, y);
      e0 = rb0 * 1000000.0;
      chk(rabs(real'(y) - e0) <= 2.0, "R8 first output b0*x", y, int'(e0));
      chk(rabs(real'(y) - e0) <= 2.0, "R7 impulse tap 0", y, int'(e0));
      push(0, y);
      e1 = rb1 * 1000000.0 - ra1 * e0;
      chk(rabs(real'(y) - e1) <= 2.0, "R7 impulse tap 1", y, int'(e1));
      push(0, y);
      e2 = -ra1 * e1;
      chk(rabs(real'(y) - e2) <= 2.0, "R7 impulse tap 2", y, int'(e2));

      // R5: DC gain, positive then negative level
      for (int i = 0; i < 60; i++) push(3000000, y);
      chk((y - 3000000) <= 4 && (3000000 - y) <= 4, "R5 DC positive", y, 3000000);
      for (int i = 0; i < 60; i++) push(-5000000, y);
      chk((y + 5000000) <= 4 && (-5000000 - y) <= 4, "R5 DC negative", y, -5000000);

      // R6: alternating input near Nyquist
      for (int i = 0; i < 80; i++) begin
         push(2000000, yp);
         push(-2000000, yn);
      end
      amp = (real'(yp) - real'(yn)) / 2.0 / 2000000.0;
      chk(rabs(amp - 0.3) <= 0.003, "R6 Nyquist gain x1e6", int'(amp * 1.0e6), 300000);

      // R8: history built at DC, then one bypass sample via speed code, then impulse
      for (int i = 0; i < 20; i++) push(4000000, y);
      speed_mode = 2'b01;
      push(123, y);
      chk(y == 123, "R4 bypass during switch", y, 123);
      speed_mode = 2'b00;
      push(-1500000, y);
      e0 = rb0 * -1500000.0;
      chk(rabs(real'(y) - e0) <= 2.0, "R8 cleared after speed switch", y, int'(e0));

      // R8: same via enable bit
      for (int i = 0; i < 20; i++) push(-4000000, y);
      deemph_en = 1'b0;
      push(7, y);
      chk(y == 7, "R3 bypass during switch", y, 7);
      deemph_en = 1'b1;
      push(2500000, y);
      e0 = rb0 * 2500000.0;
      chk(rabs(real'(y) - e0) <= 2.0, "R8 cleared after enable toggle", y, int'(e0));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule